// File: doc/BRIEF.md
# Nibble-Serial Converter Sample Link

This block carries 16-bit sample words between the modem datapath and an external data converter over three 4-bit buses. The converter supplies receive nibbles and a start-of-word strobe that marks the first nibble of each group of four. The block drives transmit nibbles and echo nibbles back to it. On the receive side the block packs each group of four nibbles into one parallel word and flags it with a one-cycle valid pulse. On the transmit side it takes one parallel transmit word and one parallel echo word per group and sends both out, most significant nibble first, in lockstep.

Everything runs in the nibble clock domain, which is four times the word rate (35.2 MHz for an 8.8 MHz word rate). After the first strobe, a nibble counter keeps the group framing going on its own. A later strobe re-aligns the counter and drops any partial word. A loopback control feeds the block's own transmit nibbles into the receive packer in place of the converter input, for self-test. A low-power request from the core is passed to the converter as a registered power-down output. While the request is active, the transmit buses are silenced and received words are suppressed.

Top module: `afe_nibble_link`

## Requirements
- R1: During and right after synchronous reset, afe_tx_nib_o, afe_echo_nib_o, rx_word_o, rx_valid_o and afe_lp_o are all zero.
- R2: Until afe_sow_i has been sampled high once after reset, receive nibbles are ignored and rx_valid_o stays low.
- R3: The nibble sampled together with a high afe_sow_i is bits 15:12 of the received word. The next three sampled nibbles are bits 11:8, 7:4 and 3:0. The word appears on rx_word_o with rx_valid_o high for exactly one cycle, starting right after the clock edge that samples bits 3:0.
- R4: After the first strobe, the nibble counter wraps every four cycles, so a new group starts even when afe_sow_i is low.
- R5: A strobe sampled before a group is complete restarts the group at bits 15:12. The partial word is dropped and raises no valid pulse.
- R6: tx_word_i is latched on the clock edge that samples the fourth nibble of a group. It is driven on afe_tx_nib_o as bits 15:12, 11:8, 7:4 and 3:0 over the next four cycles, so its top nibble falls in the first slot of the following group.
- R7: echo_word_i is latched on the same edge as tx_word_i and sent on afe_echo_nib_o in the same nibble order, aligned slot for slot with afe_tx_nib_o.
- R8: Before any transmit word has been latched after reset, afe_tx_nib_o and afe_echo_nib_o are zero.
- R9: When loop_en_i is high, the receive packer samples afe_tx_nib_o instead of afe_rx_nib_i. The received word equals the nibbles sent on the transmit bus in that group, and afe_rx_nib_i has no effect.
- R10: afe_lp_o equals the value lp_req_i had at the previous clock edge.
- R11: From the cycle after lp_req_i is sampled high, afe_tx_nib_o and afe_echo_nib_o are zero. No valid pulse is produced at an edge where lp_req_i is high.
- R12: rx_word_o holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock (four times the word rate) |
| rst | input | 1 | Synchronous active-high reset |
| lp_req_i | input | 1 | Low-power request from the core |
| loop_en_i | input | 1 | Route transmit nibbles into the receive packer |
| afe_sow_i | input | 1 | Start-of-word strobe from the converter |
| afe_rx_nib_i | input | 4 | Receive nibble from the converter |
| tx_word_i | input | 16 | Parallel transmit word |
| echo_word_i | input | 16 | Parallel echo word |
| afe_tx_nib_o | output | 4 | Transmit nibble to the converter |
| afe_echo_nib_o | output | 4 | Echo nibble to the converter |
| afe_lp_o | output | 1 | Power-down output to the converter |
| rx_word_o | output | 16 | Assembled receive word |
| rx_valid_o | output | 1 | One-cycle pulse marking a new rx_word_o |

## Verification
A received word and its valid pulse are due one register stage after the edge that samples the fourth nibble. A transmit nibble seen in a slot was chosen at the edge before it, from the word latched at the last edge of the previous group. The power-down output and the silencing of the transmit buses both lag the request by one edge. The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore sees exactly the result of the one rising edge in between. Expected transmit nibbles are taken from the word the bench applied one group earlier and from the low-power value applied one cycle earlier. Expected loopback words are built from those same expected transmit nibbles.

// File: rtl/afe_nib_pkg.sv
package afe_nib_pkg;

  localparam int unsigned DEF_NIB_W = 4;
  localparam int unsigned DEF_NIBS  = 4;

  // Per-cycle framing qualifiers shared by the datapath lanes.
  typedef struct packed {
    logic live;   // framing established (or being established this cycle)
    logic last;   // this cycle samples the final nibble of a group
  } slot_t;

endpackage

// File: rtl/nib_phase_ctrl.sv
module nib_phase_ctrl
  import afe_nib_pkg::*;
#(
  parameter int unsigned NIBS = DEF_NIBS
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sow_i,
  output slot_t slot_o
);
  localparam int unsigned IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIBS - 1);

  logic [IDX_W-1:0] ph_q;
  logic             synced_q;
  logic [IDX_W-1:0] idx;
  logic             live;

  // A strobe forces the current slot to zero, dropping any partial group.
  assign idx  = sow_i ? '0 : ph_q;
  assign live = synced_q | sow_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      synced_q <= 1'b0;
    end else begin
      if (sow_i) synced_q <= 1'b1;
      if (live) begin
        if (idx == IDX_LAST) ph_q <= '0;
        else                 ph_q <= idx + 1'b1;
      end
    end
  end

  assign slot_o.live = live;
  assign slot_o.last = live && (idx == IDX_LAST);

endmodule

// File: rtl/nib_rx_packer.sv
module nib_rx_packer
  import afe_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  slot_t                   slot_i,
  input  logic                    quiet_i,
  input  logic [NIB_W-1:0]        nib_i,
  output logic [NIB_W*NIBS-1:0]   word_o,
  output logic                    valid_o
);
  localparam int unsigned WORD_W = NIB_W * NIBS;

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_next;

  generate
    if (NIBS > 1) begin : g_multi
      assign acc_next = {acc_q[WORD_W-NIB_W-1:0], nib_i};
    end else begin : g_single
      assign acc_next = nib_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (slot_i.live) acc_q <= acc_next;
      if (slot_i.last && !quiet_i) begin
        word_o  <= acc_next;
        valid_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nib_tx_serializer.sv
module nib_tx_serializer
  import afe_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  slot_t                   slot_i,
  input  logic                    quiet_i,
  input  logic [NIB_W*NIBS-1:0]   word_i,
  output logic [NIB_W-1:0]        nib_o
);
  localparam int unsigned WORD_W = NIB_W * NIBS;

  logic [WORD_W-1:0] sh_q;
  logic [NIB_W-1:0]  nib_next;

  always_comb begin
    nib_next = '0;
    if (slot_i.last)      nib_next = word_i[WORD_W-1 -: NIB_W];
    else if (slot_i.live) nib_next = sh_q[WORD_W-1 -: NIB_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      nib_o <= '0;
    end else begin
      if (slot_i.last)      sh_q <= word_i << NIB_W;
      else if (slot_i.live) sh_q <= sh_q << NIB_W;
      nib_o <= quiet_i ? '0 : nib_next;
    end
  end

endmodule

// File: rtl/afe_nibble_link.sv
module afe_nibble_link
  import afe_nib_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter int unsigned NIBS  = DEF_NIBS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lp_req_i,
  input  logic                   loop_en_i,
  input  logic                   afe_sow_i,
  input  logic [NIB_W-1:0]       afe_rx_nib_i,
  input  logic [NIB_W*NIBS-1:0]  tx_word_i,
  input  logic [NIB_W*NIBS-1:0]  echo_word_i,
  output logic [NIB_W-1:0]       afe_tx_nib_o,
  output logic [NIB_W-1:0]       afe_echo_nib_o,
  output logic                   afe_lp_o,
  output logic [NIB_W*NIBS-1:0]  rx_word_o,
  output logic                   rx_valid_o
);
  localparam int unsigned WORD_W = NIB_W * NIBS;
  localparam int unsigned LANES  = 2;   // lane 0: transmit, lane 1: echo

  slot_t             slot;
  logic [WORD_W-1:0] lane_word [LANES];
  logic [NIB_W-1:0]  lane_nib  [LANES];
  logic [NIB_W-1:0]  rx_src;

  nib_phase_ctrl #(.NIBS(NIBS)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .sow_i  (afe_sow_i),
    .slot_o (slot)
  );

  assign lane_word[0] = tx_word_i;
  assign lane_word[1] = echo_word_i;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      nib_tx_serializer #(.NIB_W(NIB_W), .NIBS(NIBS)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .slot_i  (slot),
        .quiet_i (lp_req_i),
        .word_i  (lane_word[l]),
        .nib_o   (lane_nib[l])
      );
    end
  endgenerate

  assign afe_tx_nib_o   = lane_nib[0];
  assign afe_echo_nib_o = lane_nib[1];

  // Input selector ahead of the receive packer.
  assign rx_src = loop_en_i ? lane_nib[0] : afe_rx_nib_i;

  nib_rx_packer #(.NIB_W(NIB_W), .NIBS(NIBS)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .slot_i  (slot),
    .quiet_i (lp_req_i),
    .nib_i   (rx_src),
    .word_o  (rx_word_o),
    .valid_o (rx_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) afe_lp_o <= 1'b0;
    else     afe_lp_o <= lp_req_i;
  end

endmodule

// File: rtl/afe_nibble_link_chk.sv
module afe_nibble_link_chk #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned NIBS  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   lp_req_i,
  input logic                   afe_sow_i,
  input logic [NIB_W-1:0]       afe_tx_nib_o,
  input logic [NIB_W-1:0]       afe_echo_nib_o,
  input logic                   afe_lp_o,
  input logic [NIB_W*NIBS-1:0]  rx_word_o,
  input logic                   rx_valid_o
);
  logic seen_sow_q;

  always_ff @(posedge clk) begin
    if (rst)            seen_sow_q <= 1'b0;
    else if (afe_sow_i) seen_sow_q <= 1'b1;
  end

  p_no_valid_before_sync_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> seen_sow_q);

  p_valid_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  p_lp_follows_request_r10: assert property (@(posedge clk) disable iff (rst)
    lp_req_i |=> afe_lp_o);

  p_lp_release_r10: assert property (@(posedge clk) disable iff (rst)
    !lp_req_i |=> !afe_lp_o);

  p_quiet_tx_r11: assert property (@(posedge clk) disable iff (rst)
    lp_req_i |=> (afe_tx_nib_o == '0 && afe_echo_nib_o == '0));

  p_quiet_no_valid_r11: assert property (@(posedge clk) disable iff (rst)
    lp_req_i |=> !rx_valid_o);

  p_word_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_o |-> $stable(rx_word_o));

endmodule

bind afe_nibble_link afe_nibble_link_chk #(.NIB_W(NIB_W), .NIBS(NIBS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lp_req_i       (lp_req_i),
  .afe_sow_i      (afe_sow_i),
  .afe_tx_nib_o   (afe_tx_nib_o),
  .afe_echo_nib_o (afe_echo_nib_o),
  .afe_lp_o       (afe_lp_o),
  .rx_word_o      (rx_word_o),
  .rx_valid_o     (rx_valid_o)
);

// File: tb/tb_afe_nibble_link.sv
module tb_afe_nibble_link;
  logic        clk = 1'b0;
  logic        rst;
  logic        lp_req_i, loop_en_i, afe_sow_i;
  logic [3:0]  afe_rx_nib_i;
  logic [15:0] tx_word_i, echo_word_i;
  logic [3:0]  afe_tx_nib_o, afe_echo_nib_o;
  logic        afe_lp_o;
  logic [15:0] rx_word_o;
  logic        rx_valid_o;

  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  // Bench-side expectations
  bit          have_prev;
  bit          last_lp;
  logic [15:0] prev_tx, prev_echo, held;

  always #10 clk = ~clk;

  afe_nibble_link dut (
    .clk(clk), .rst(rst), .lp_req_i(lp_req_i), .loop_en_i(loop_en_i),
    .afe_sow_i(afe_sow_i), .afe_rx_nib_i(afe_rx_nib_i),
    .tx_word_i(tx_word_i), .echo_word_i(echo_word_i),
    .afe_tx_nib_o(afe_tx_nib_o), .afe_echo_nib_o(afe_echo_nib_o),
    .afe_lp_o(afe_lp_o), .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [3:0] nib_of(input logic [15:0] w, input int k);
    return w[15-4*k -: 4];
  endfunction

  // Drive at the current falling edge, return at the next falling edge.
  task automatic cyc(input logic s, input logic [3:0] n);
    afe_sow_i    = s;
    afe_rx_nib_i = n;
    @(posedge clk);
    @(negedge clk);
    last_lp = lp_req_i;
  endtask

  // One four-slot group.
  task automatic group(input bit s0, input bit lp, input bit lb, input bit chk_tx,
                       input string rtag);
    logic [15:0] rw, nw, ew, loop_exp;
    logic [3:0]  et, ee;
    rw = 16'($urandom); nw = 16'($urandom); ew = 16'($urandom);
    tx_word_i = nw; echo_word_i = ew; lp_req_i = lp; loop_en_i = lb;
    loop_exp = '0;
    for (int k = 0; k < 4; k++) begin
      et = last_lp ? 4'h0 : (have_prev ? nib_of(prev_tx, k)   : 4'h0);
      ee = last_lp ? 4'h0 : (have_prev ? nib_of(prev_echo, k) : 4'h0);
      loop_exp = {loop_exp[11:0], et};
      if (chk_tx) begin
        check(afe_tx_nib_o == et, last_lp ? "R11" : (have_prev ? "R6" : "R8"),
              "tx nibble", 16'(afe_tx_nib_o), 16'(et));
        check(afe_echo_nib_o == ee, last_lp ? "R11" : (have_prev ? "R7" : "R8"),
              "echo nibble", 16'(afe_echo_nib_o), 16'(ee));
      end
      check(afe_lp_o == last_lp, "R10", "power-down out", 16'(afe_lp_o), 16'(last_lp));
      cyc((k == 0) ? s0 : 1'b0, nib_of(rw, k));
      if (k < 3) begin
        check(rx_valid_o == 1'b0, rtag, "valid mid-group", 16'(rx_valid_o), 16'h0);
        check(rx_word_o == held, "R12", "word held", rx_word_o, held);
      end else if (lp) begin
        check(rx_valid_o == 1'b0, "R11", "valid in low power", 16'(rx_valid_o), 16'h0);
        check(rx_word_o == held, "R12", "word held", rx_word_o, held);
      end else begin
        check(rx_valid_o == 1'b1, rtag, "valid at group end", 16'(rx_valid_o), 16'h1);
        if (lb) begin
          check(rx_word_o == loop_exp, "R9", "loopback word", rx_word_o, loop_exp);
          held = loop_exp;
        end else begin
          check(rx_word_o == rw, rtag, "received word", rx_word_o, rw);
          held = rw;
        end
      end
    end
    prev_tx = nw; prev_echo = ew; have_prev = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst = 1; lp_req_i = 0; loop_en_i = 0; afe_sow_i = 0; afe_rx_nib_i = 0;
    tx_word_i = 0; echo_word_i = 0;
    have_prev = 0; last_lp = 0; prev_tx = 0; prev_echo = 0; held = 0;
    @(negedge clk);
    repeat (3) cyc(0, 4'hF);
    // R1: reset state
    check(afe_tx_nib_o == 0 && afe_echo_nib_o == 0, "R1", "tx/echo at reset",
          {afe_tx_nib_o, afe_echo_nib_o}, 16'h0);
    check(rx_word_o == 0 && rx_valid_o == 0, "R1", "rx at reset", rx_word_o, 16'h0);
    check(afe_lp_o == 0, "R1", "lp at reset", 16'(afe_lp_o), 16'h0);
    rst = 0;

    // R2 and R8: nibbles without a strobe are ignored
    for (int i = 0; i < 7; i++) begin
      tx_word_i = 16'($urandom);
      cyc(0, 4'($urandom));
      check(rx_valid_o == 0, "R2", "valid before sync", 16'(rx_valid_o), 16'h0);
      check(afe_tx_nib_o == 0, "R8", "tx before sync", 16'(afe_tx_nib_o), 16'h0);
    end

    // First aligned groups: R3, R6, R7, R8
    group(1, 0, 0, 1, "R3");
    group(1, 0, 0, 1, "R3");
    group(1, 0, 0, 1, "R3");
    // Free-running without strobes: R4
    group(0, 0, 0, 1, "R4");
    group(0, 0, 0, 1, "R4");

    // R5: strobe after two nibbles drops the partial word
    cyc(1, 4'hA);
    check(rx_valid_o == 0, "R5", "partial slot0", 16'(rx_valid_o), 16'h0);
    cyc(0, 4'h5);
    check(rx_valid_o == 0, "R5", "partial slot1", 16'(rx_valid_o), 16'h0);
    have_prev = 0;
    group(1, 0, 0, 0, "R5");
    group(1, 0, 0, 1, "R5");

    // R9: loopback, converter nibbles differ and must be ignored
    group(1, 0, 1, 1, "R9");
    group(0, 0, 1, 1, "R9");
    // R11 and R10: low-power group, then release
    group(1, 1, 0, 1, "R11");
    group(1, 0, 0, 1, "R11");
    group(1, 0, 1, 1, "R9");

    // Constrained random groups
    for (int g = 0; g < 60; g++) begin
      int r;
      bit s0, lp, lb;
      r  = int'($urandom_range(0, 99));
      s0 = (r % 5) != 0;
      lp = ($urandom_range(0, 99) < 15);
      lb = ($urandom_range(0, 99) < 25);
      group(s0, lp, lb, 1, s0 ? "R3" : "R4");
    end
    lp_req_i = 0; loop_en_i = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule